// File: doc/BRIEF.md
# Window Watchdog Supervisor

This block supervises a host processor by timing the rising edges of its service signal. It counts ticks of an independent watchdog tick enable. When the processor reset is released, the block first waits through one long initial timeout for a first service edge. After that edge it enforces a window. A short closed phase comes first, and no edge may arrive during it. An open phase follows, and the next edge must arrive before it ends.

The service input is deglitched before use. Every fault gives a one-cycle fault pulse, a fault-class code and, if a build option selects it, a request that the regulators shut down and restart. A fault then drives the processor reset low for a programmable delay plus three ticks. Supervision is suspended while an external cause already holds the reset, and while a debug strap is set. All times are parameters counted in ticks. The closed phase is one quarter of the open phase.

The block has no data stream, so all of its pins are plain control and status levels or pulses.

Top module: `wdg_window_supervisor`

## Requirements
- R1: After the reset is released with the filtered service input low, a fault of class 1 is raised if no accepted rising edge arrives within FIRST_TICKS ticks.
- R2: An accepted rising edge less than OPEN_TICKS/4 ticks after the window started raises a fault of class 2.
- R3: An accepted rising edge at or after OPEN_TICKS/4 ticks and before OPEN_TICKS ticks raises no fault and restarts both window phases.
- R4: If no accepted rising edge arrives within OPEN_TICKS ticks of the window start, a fault of class 3 is raised.
- R5: If the filtered service input stays high for the whole open window, the expiry is reported as class 4 instead of class 3.
- R6: If the filtered service input is already high when the reset is released, the windows start at once and the first timeout is skipped.
- R7: A level on the service input is accepted only after it has been held for DEB_TICKS (default 3) consecutive ticks. Shorter pulses have no effect.
- R8: After any fault, host_rst_n is low for exactly RST_DELAY_TICKS+3 ticks. Supervision then restarts with the first timeout.
- R9: While ext_hold is high, host_rst_n is low and supervision is suspended. While dbg_strap is high, supervision is suspended and host_rst_n stays high.
- R10: fault_pulse is high for one cycle per fault, and fault_code then holds the class (1 first timeout, 2 early, 3 late, 4 stuck high). Both are 0 after reset. shut_req pulses with fault_pulse when SHUTDOWN_ON_FAULT is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Watchdog time base, one-cycle enable per tick |
| wdi | input | 1 | Synchronous service input from the host |
| ext_hold | input | 1 | Reset held by output regulation or global fault |
| dbg_strap | input | 1 | Debug strap that suspends supervision |
| host_rst_n | output | 1 | Processor reset, active low |
| fault_pulse | output | 1 | One-cycle fault indication |
| fault_code | output | 3 | Class of the most recent fault |
| shut_req | output | 1 | Regulator shutdown-and-restart request pulse |

## Verification
The bench targets the boundary between the closed and open phases. A design that measured the closed phase wrongly would flag a healthy service edge or let an early one pass. It releases reset with the service input already high. A design that ignored that level would report a first-timeout fault rather than an open-window expiry. It sends glitches shorter than the filter length and a pulse held high through the whole window. It also measures the exact length of the post-fault reset, where an off-by-one hold counter shows up at once. A design that kept counting while suspended would raise a fault during the debug-strap interval.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    ST_SUSP  = 2'd0,
    ST_FIRST = 2'd1,
    ST_WIN   = 2'd2,
    ST_HOLD  = 2'd3
  } wdg_state_e;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_FIRST = 3'd1,
    FC_EARLY = 3'd2,
    FC_LATE  = 3'd3,
    FC_STUCK = 3'd4
  } wdg_fault_e;

endpackage

// File: rtl/wdg_deglitch.sv
module wdg_deglitch #(
  parameter int DEB_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic lvl,
  output logic rise
);
  localparam int CW = $clog2(DEB_TICKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= 1'b0;
      cnt  <= '0;
      rise <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (raw == lvl) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CW'(DEB_TICKS - 1)) begin
          lvl  <= raw;
          cnt  <= '0;
          rise <= raw;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_filter_follows_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> (lvl == $past(raw)));

  assert_rise_is_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> lvl);

endmodule

// File: rtl/wdg_sequencer.sv
module wdg_sequencer
  import wdg_pkg::*;
#(
  parameter int FIRST_TICKS  = 30,
  parameter int OPEN_TICKS   = 2000,
  parameter int CLOSED_TICKS = 500,
  parameter int HOLD_TICKS   = 503
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       lvl,
  input  logic       rise,
  input  logic       ext_hold,
  input  logic       dbg,
  output logic       fault_p,
  output wdg_fault_e fault_code,
  output logic       in_hold
);
  localparam int MAX_A = (FIRST_TICKS > OPEN_TICKS) ? FIRST_TICKS : OPEN_TICKS;
  localparam int MAX_T = (MAX_A > HOLD_TICKS) ? MAX_A : HOLD_TICKS;
  localparam int TW    = $clog2(MAX_T + 1);

  wdg_state_e  st;
  logic [TW-1:0] tcnt;
  logic        low_seen;
  logic        suspend;

  assign suspend = ext_hold | dbg;
  assign in_hold = (st == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_SUSP;
      tcnt       <= '0;
      low_seen   <= 1'b0;
      fault_p    <= 1'b0;
      fault_code <= FC_NONE;
    end else begin
      fault_p <= 1'b0;
      if (suspend) begin
        st   <= ST_SUSP;
        tcnt <= '0;
      end else begin
        case (st)
          ST_SUSP: begin
            tcnt     <= '0;
            low_seen <= 1'b0;
            st       <= lvl ? ST_WIN : ST_FIRST;
          end
          ST_FIRST: begin
            if (rise) begin
              st       <= ST_WIN;
              tcnt     <= '0;
              low_seen <= 1'b0;
            end else if (tick) begin
              if (tcnt == TW'(FIRST_TICKS - 1)) begin
                st         <= ST_HOLD;
                tcnt       <= '0;
                fault_p    <= 1'b1;
                fault_code <= FC_FIRST;
              end else begin
                tcnt <= tcnt + 1'b1;
              end
            end
          end
          ST_WIN: begin
            if (!lvl) low_seen <= 1'b1;
            if (rise) begin
              if (tcnt < TW'(CLOSED_TICKS)) begin
                st         <= ST_HOLD;
                tcnt       <= '0;
                fault_p    <= 1'b1;
                fault_code <= FC_EARLY;
              end else begin
                tcnt     <= '0;
                low_seen <= 1'b0;
              end
            end else if (tick) begin
              if (tcnt == TW'(OPEN_TICKS - 1)) begin
                st         <= ST_HOLD;
                tcnt       <= '0;
                fault_p    <= 1'b1;
                fault_code <= (low_seen || !lvl) ? FC_LATE : FC_STUCK;
              end else begin
                tcnt <= tcnt + 1'b1;
              end
            end
          end
          default: begin
            if (tick) begin
              if (tcnt == TW'(HOLD_TICKS - 1)) begin
                tcnt     <= '0;
                low_seen <= 1'b0;
                st       <= lvl ? ST_WIN : ST_FIRST;
              end else begin
                tcnt <= tcnt + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assert_fault_enters_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_p |-> (st == ST_HOLD));

  assert_hold_suspends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_hold || dbg) |=> (st == ST_SUSP));

  assert_fault_has_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_p |-> (fault_code != FC_NONE));

  assert_early_edge_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !suspend && st == ST_WIN && tcnt < TW'(CLOSED_TICKS)) |=>
      (fault_p && fault_code == FC_EARLY));

  assert_hold_leaves_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD && $past(st) != ST_HOLD) |-> (tcnt == '0));

endmodule

// File: rtl/wdg_window_supervisor.sv
module wdg_window_supervisor
  import wdg_pkg::*;
#(
  parameter int FIRST_TICKS       = 30,
  parameter int OPEN_TICKS        = 2000,
  parameter int RST_DELAY_TICKS   = 500,
  parameter int DEB_TICKS         = 3,
  parameter bit SHUTDOWN_ON_FAULT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wdi,
  input  logic       ext_hold,
  input  logic       dbg_strap,
  output logic       host_rst_n,
  output logic       fault_pulse,
  output logic [2:0] fault_code,
  output logic       shut_req
);
  localparam int CLOSED_TICKS = OPEN_TICKS / 4;
  localparam int HOLD_TICKS   = RST_DELAY_TICKS + 3;

  logic       lvl;
  logic       rise;
  logic       fault_p;
  logic       in_hold;
  wdg_fault_e code;

  wdg_deglitch #(.DEB_TICKS(DEB_TICKS)) u_deglitch (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_en),
    .raw  (wdi),
    .lvl  (lvl),
    .rise (rise)
  );

  wdg_sequencer #(
    .FIRST_TICKS (FIRST_TICKS),
    .OPEN_TICKS  (OPEN_TICKS),
    .CLOSED_TICKS(CLOSED_TICKS),
    .HOLD_TICKS  (HOLD_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en),
    .lvl       (lvl),
    .rise      (rise),
    .ext_hold  (ext_hold),
    .dbg       (dbg_strap),
    .fault_p   (fault_p),
    .fault_code(code),
    .in_hold   (in_hold)
  );

  assign host_rst_n  = !in_hold && !ext_hold;
  assign fault_pulse = fault_p;
  assign fault_code  = code;

  generate
    if (SHUTDOWN_ON_FAULT) begin : g_shut
      assign shut_req = fault_p;
    end else begin : g_noshut
      assign shut_req = 1'b0;
    end
  endgenerate

  assert_single_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);

  assert_fault_drops_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> !host_rst_n);

endmodule

// File: tb/tb_wdg_window_supervisor.sv
`timescale 1ns/1ps
module tb_wdg_window_supervisor;
  localparam int FT = 30;
  localparam int OT = 40;
  localparam int RD = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic tick_en = 1;
  logic wdi = 0;
  logic ext_hold = 1;
  logic dbg_strap = 0;
  logic host_rst_n, fault_pulse, shut_req;
  logic [2:0] fault_code;

  int errors = 0;
  int checks = 0;
  int fault_cnt = 0;
  int shut_cnt = 0;
  int low_run = 0;
  int last_low = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdg_window_supervisor #(
    .FIRST_TICKS(FT), .OPEN_TICKS(OT), .RST_DELAY_TICKS(RD),
    .DEB_TICKS(3), .SHUTDOWN_ON_FAULT(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wdi(wdi),
    .ext_hold(ext_hold), .dbg_strap(dbg_strap), .host_rst_n(host_rst_n),
    .fault_pulse(fault_pulse), .fault_code(fault_code), .shut_req(shut_req)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (fault_pulse) fault_cnt++;
      if (shut_req) shut_cnt++;
      if (!host_rst_n && !ext_hold) low_run++;
      else if (low_run > 0) begin last_low = low_run; low_run = 0; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_with(input logic lvl);
    ext_hold = 1; wdi = lvl;
    cyc(6);
    ext_hold = 0;
  endtask

  task automatic pulse(input int w);
    wdi = 1; cyc(w); wdi = 0;
  endtask

  // gap between two service edges in cycles, expected class (0 = none)
  localparam int VEC [4][2] = '{'{8, 2}, '{18, 0}, '{30, 0}, '{70, 3}};

  initial begin
    int base;
    cyc(3);
    rst_n = 1;
    cyc(2);
    // reset state
    check(fault_code == 3'd0, "R10 reset code", fault_code, 0);
    check(fault_pulse == 1'b0, "R10 reset pulse", fault_pulse, 0);
    check(host_rst_n == 1'b0, "R9 ext_hold drives reset", host_rst_n, 0);

    // vector table: window phases
    foreach (VEC[i]) begin
      release_with(1'b0);
      cyc(2);
      base = fault_cnt;
      pulse(4);
      cyc(VEC[i][0] - 4);
      pulse(4);
      cyc(11);
      if (VEC[i][1] == 0)
        check(fault_cnt == base, "R3 valid gap no fault", fault_cnt - base, 0);
      else begin
        check(fault_cnt == base + 1, (VEC[i][1] == 2) ? "R2 early count" : "R4 late count",
              fault_cnt - base, 1);
        check(fault_code == 3'(VEC[i][1]), (VEC[i][1] == 2) ? "R2 early class" : "R4 late class",
              fault_code, VEC[i][1]);
      end
    end

    // R1 first timeout, R8 hold length and re-entry
    release_with(1'b0);
    base = fault_cnt;
    cyc(25);
    check(fault_cnt == base, "R1 no fault before timeout", fault_cnt - base, 0);
    cyc(15);
    check(fault_cnt == base + 1, "R1 timeout fault", fault_cnt - base, 1);
    check(fault_code == 3'd1, "R1 timeout class", fault_code, 1);
    cyc(10);
    check(last_low == RD + 3, "R8 hold length", last_low, RD + 3);
    cyc(30);
    check(fault_cnt == base + 2, "R8 first timeout re-entered", fault_cnt - base, 2);

    // R5 stuck high
    release_with(1'b0);
    cyc(2);
    wdi = 1;
    cyc(50);
    check(fault_code == 3'd4, "R5 stuck class", fault_code, 4);
    wdi = 0;

    // R6 high at release
    release_with(1'b1);
    base = fault_cnt;
    cyc(5);
    wdi = 0;
    cyc(31);
    check(fault_cnt == base, "R6 no first timeout", fault_cnt - base, 0);
    cyc(14);
    check(fault_code == 3'd3, "R6 window started at release", fault_code, 3);

    // R7 short glitches ignored
    release_with(1'b0);
    base = fault_cnt;
    for (int k = 0; k < 8; k++) begin pulse(2); cyc(3); end
    cyc(5);
    check(fault_cnt == base + 1, "R7 glitches ignored", fault_cnt - base, 1);
    check(fault_code == 3'd1, "R7 glitch class", fault_code, 1);

    // R7 three-tick pulse accepted
    release_with(1'b0);
    base = fault_cnt;
    cyc(2);
    pulse(3);
    cyc(17);
    pulse(3);
    cyc(20);
    check(fault_cnt == base, "R7 min pulse accepted", fault_cnt - base, 0);

    // R9 debug strap suspends without reset
    ext_hold = 1; cyc(3);
    dbg_strap = 1; ext_hold = 0;
    base = fault_cnt;
    cyc(100);
    check(fault_cnt == base, "R9 dbg suspends", fault_cnt - base, 0);
    check(host_rst_n == 1'b1, "R9 dbg keeps reset high", host_rst_n, 1);
    dbg_strap = 0;
    cyc(40);
    check(fault_cnt == base + 1, "R9 resumes after dbg", fault_cnt - base, 1);

    // R10 shutdown request mirrors faults
    check(shut_cnt == fault_cnt, "R10 shut_req per fault", shut_cnt, fault_cnt);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule